// File: doc/BRIEF.md
# Dual-Bank DRAM Cycle Controller

This block sequences the cycles of a dynamic memory made of two independent 4K banks on a simple request/acknowledge bus. Each bank has its own 4K-aligned base, given by the upper address bits. When a request decodes to a bank, the block runs a fixed-length cycle. It raises that bank's cycle-enable strobe and returns a one-cycle acknowledge at the end. Addresses that fall in neither window get no cycle and no stall.

The memory address port is fed by a two-way selector, driven from a register. The selector picks either the low bus address bits or an internal refresh row counter. A timer interleaves refresh cycles, which strobe both banks at once. The selector is set one cycle before the strobe rises and is flipped partway through the strobe. The flip comes only after the memory has latched its address and the required hold time has passed. A three-position write-protect input can block every write to both banks, while reads still run.

Top module: `dram_bank_ctrl`

## Requirements
- R1: A request whose address bits [15:12] equal `base0` (or `base1`) strobes only `cen[0]` (or `cen[1]`), and `mem_addr` equals address bits [11:0] while the strobe is high before the selector flips.
- R2: When both bases name the same 4K region, bank 0 alone is strobed. An access never strobes more than one bank.
- R3: `protect_sel` codes 2'b00 and 2'b01 allow writes, so `mem_we` of the selected bank follows the strobe for a write. Codes 2'b10 and 2'b11 keep `mem_we` at zero. Under protection the cycle still runs and is acknowledged.
- R4: `mux_refresh` holds steady across every rising edge of a strobe. It is 0 for a bus access and 1 for a refresh.
- R5: Every strobe lasts STROBE_CLKS cycles (20 by default). `mux_refresh` flips ceil(HOLD_NS/CLK_NS) cycles after the strobe rises (13 at 250 ns and 20 ns), which is never less than MIN_HOLD_NS (150 ns).
- R6: A refresh cycle is started once every REF_PERIOD cycles. It strobes both banks (`cen` = 2'b11) with `mem_we` zero, and `mem_addr` is the row counter zero-extended.
- R7: The row counter starts at 0 and advances by one after each refresh. It wraps from 2**ROW_W-1 (63) back to 0.
- R8: A decoded request that arrives while a refresh is pending or running keeps `bus_wait` high until the refresh ends. Its own strobe starts after the refresh strobe falls.
- R9: A request that matches neither base produces no strobe, no `bus_wait` and no `bus_ack`.
- R10: After reset, `cen`, `mem_we`, `bus_wait`, `bus_ack` and `mux_refresh` are all 0.
- R11: `bus_ack` is a one-cycle pulse in the last strobe cycle of an access. `bus_wait` is high while a decoded request is not yet acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write access |
| bus_addr | input | 16 | Bus address |
| base0 | input | 4 | 4K window of bank 0 |
| base1 | input | 4 | 4K window of bank 1 |
| protect_sel | input | 2 | Write-protect position (10/11 protect) |
| mem_addr | output | 12 | Selected memory address |
| mux_refresh | output | 1 | Selector state, 1 = refresh row |
| cen | output | 2 | Per-bank cycle-enable strobe |
| mem_we | output | 2 | Per-bank write enable |
| bus_wait | output | 1 | Stall for a decoded request |
| bus_ack | output | 1 | Access complete pulse |

## Verification
Accesses are run as reads and writes to each bank, and under every protect code. This separates bank decode errors from write-gating errors. Two checks cover the decode corners: equal bases show whether bank 0 wins, and an address outside both windows shows that a miss stays silent. Each access measures the strobe length and the distance from the strobe rise to the selector flip. These measurements catch a flip placed at the wrong cycle or a selector that moves on the strobe edge. A monitor follows every refresh through a full wrap of the row counter, and a request placed inside a refresh shows the stall.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  // round a time in ns up to whole clock cycles
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // true when the upper address bits name the given 4K window
  function automatic logic window_hit(input logic [3:0] upper, input logic [3:0] base);
    return upper == base;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE} seq_state_t;
endpackage

// File: rtl/dbc_decode.sv
module dbc_decode #(
  parameter int ADDR_W = 16,
  parameter int BANK_AW = 12
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-BANK_AW-1:0] base0,
  input  logic [ADDR_W-BANK_AW-1:0] base1,
  output logic                      hit,
  output logic                      bank
);
  import dbc_pkg::*;
  logic hit0, hit1;
  assign hit0 = window_hit(addr[ADDR_W-1:BANK_AW], base0);
  assign hit1 = window_hit(addr[ADDR_W-1:BANK_AW], base1);
  assign hit  = hit0 | hit1;
  // bank 0 wins when both windows overlap
  assign bank = hit0 ? 1'b0 : 1'b1;
endmodule

// File: rtl/dbc_refresh.sv
module dbc_refresh #(
  parameter int ROW_W = 6,
  parameter int REF_PERIOD = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] row
);
  localparam int TW = $clog2(REF_PERIOD + 1);
  logic [TW-1:0] tick;
  logic          tick_end;

  assign tick_end = (tick == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= '0;
      ref_pend <= 1'b0;
      row      <= '0;
    end else begin
      tick <= tick_end ? '0 : tick + 1'b1;
      if (tick_end)       ref_pend <= 1'b1;
      else if (ref_start) ref_pend <= 1'b0;
      if (ref_done) row <= row + 1'b1;
    end
  end

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> row == $past(row) + 1'b1);
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq #(
  parameter int STROBE_CLKS = 20,
  parameter int HOLD_CLKS = 13,
  parameter int CLK_NS = 20,
  parameter int MIN_HOLD_NS = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_go,
  input  logic       acc_bank,
  input  logic       acc_we,
  input  logic       protect,
  input  logic       ref_pend,
  output logic [1:0] cen,
  output logic [1:0] mem_we,
  output logic       mux_ref,
  output logic       ref_start,
  output logic       ref_done,
  output logic       bus_ack
);
  import dbc_pkg::*;
  localparam int CW = $clog2(STROBE_CLKS + 1);

  seq_state_t    state;
  logic          kind_ref, bank_q, we_q;
  logic [CW-1:0] cnt;
  logic          last, in_strobe;
  logic [1:0]    bank_oh;

  assign in_strobe = (state == ST_STROBE);
  assign last      = in_strobe && (cnt == CW'(STROBE_CLKS - 1));
  assign ref_start = (state == ST_IDLE) && ref_pend;
  assign ref_done  = last && kind_ref;
  assign bus_ack   = last && !kind_ref;
  assign bank_oh   = bank_q ? 2'b10 : 2'b01;
  assign cen       = in_strobe ? (kind_ref ? 2'b11 : bank_oh) : 2'b00;
  assign mem_we    = (in_strobe && !kind_ref && we_q) ? bank_oh : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_ref <= 1'b0;
      bank_q   <= 1'b0;
      we_q     <= 1'b0;
      mux_ref  <= 1'b0;
      cnt      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            kind_ref <= 1'b1;
            mux_ref  <= 1'b1;
            state    <= ST_SETUP;
          end else if (acc_go) begin
            kind_ref <= 1'b0;
            bank_q   <= acc_bank;
            we_q     <= acc_we & ~protect;
            mux_ref  <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt   <= '0;
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HOLD_CLKS - 1)) mux_ref <= !kind_ref;
          if (last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_mux_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_strobe) |-> $stable(mux_ref));
  a_r5_hold_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && $past(in_strobe) && mux_ref != $past(mux_ref))
      |-> (int'(cnt) * CLK_NS >= MIN_HOLD_NS));
  a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !kind_ref) |-> $onehot0(cen));
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl #(
  parameter int ADDR_W = 16,
  parameter int BANK_AW = 12,
  parameter int ROW_W = 6,
  parameter int CLK_NS = 20,
  parameter int HOLD_NS = 250,
  parameter int MIN_HOLD_NS = 150,
  parameter int STROBE_CLKS = 20,
  parameter int REF_PERIOD = 200
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_req,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [ADDR_W-BANK_AW-1:0] base0,
  input  logic [ADDR_W-BANK_AW-1:0] base1,
  input  logic [1:0]                protect_sel,
  output logic [BANK_AW-1:0]        mem_addr,
  output logic                      mux_refresh,
  output logic [1:0]                cen,
  output logic [1:0]                mem_we,
  output logic                      bus_wait,
  output logic                      bus_ack
);
  import dbc_pkg::*;
  localparam int HOLD_CLKS = ns_to_cycles(HOLD_NS, CLK_NS);

  logic             hit, bank, ref_pend, ref_start, ref_done, protect;
  logic [ROW_W-1:0] row;

  assign protect = protect_sel[1];

  dbc_decode #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) u_dec (
    .addr(bus_addr), .base0(base0), .base1(base1), .hit(hit), .bank(bank));

  dbc_refresh #(.ROW_W(ROW_W), .REF_PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_done(ref_done),
    .ref_pend(ref_pend), .row(row));

  dbc_seq #(.STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS),
            .CLK_NS(CLK_NS), .MIN_HOLD_NS(MIN_HOLD_NS)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_go(bus_req & hit), .acc_bank(bank),
    .acc_we(bus_we), .protect(protect), .ref_pend(ref_pend), .cen(cen),
    .mem_we(mem_we), .mux_ref(mux_refresh), .ref_start(ref_start),
    .ref_done(ref_done), .bus_ack(bus_ack));

  assign mem_addr = mux_refresh ? BANK_AW'(row) : bus_addr[BANK_AW-1:0];
  assign bus_wait = bus_req & hit & ~bus_ack;

  a_r9_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !hit) |-> (!bus_wait && !bus_ack));
  a_r6_refresh_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cen == 2'b11) |-> (mem_we == 2'b00));
  a_r3_protect_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|cen) && protect) |-> (mem_we == 2'b00));
endmodule

// File: tb/tb_dram_bank_ctrl.sv
module tb_dram_bank_ctrl;
  localparam int CLK_PERIOD = 20;
  localparam int STROBE = 20;
  localparam int HOLD = 13;

  logic        clk = 0, rst_n = 0, bus_req = 0, bus_we = 0;
  logic [15:0] bus_addr = '0;
  logic [3:0]  base0 = 4'h3, base1 = 4'h9;
  logic [1:0]  protect_sel = 2'b00;
  logic [11:0] mem_addr;
  logic        mux_refresh, bus_wait, bus_ack;
  logic [1:0]  cen, mem_we;

  int checks = 0, fails = 0, ref_seen = 0;
  logic [5:0] exp_row = '0;
  logic [1:0] prev_cen = '0;
  logic       mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .base0(base0), .base1(base1), .protect_sel(protect_sel),
    .mem_addr(mem_addr), .mux_refresh(mux_refresh), .cen(cen), .mem_we(mem_we),
    .bus_wait(bus_wait), .bus_ack(bus_ack));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // refresh monitor: R6, R7
  always @(negedge clk) begin
    if (mon_on && prev_cen != 2'b11 && cen == 2'b11) begin
      check(mem_addr == {6'd0, exp_row}, "R7 refresh row", mem_addr, exp_row);
      check(mux_refresh == 1'b1, "R4 refresh selector", mux_refresh, 1);
      check(mem_we == 2'b00, "R6 refresh write", mem_we, 0);
      exp_row = exp_row + 1'b1;
      ref_seen++;
    end
    prev_cen = cen;
  end

  task automatic run_access(input logic [15:0] a, input logic w, input int bk,
                            input logic exp_we, input string tag);
    int n = 0, len = 0, flip = -1;
    logic rose = 0, saw_we = 0, saw_other = 0, pmux = 0;
    logic [1:0] oh;
    oh = (bk == 1) ? 2'b10 : 2'b01;
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_req = 1;
    #1 check(bus_wait == 1'b1, {tag, " R11 wait on request"}, bus_wait, 1);
    while (!bus_ack && n < 2000) begin
      @(negedge clk); n++;
      if (cen == oh) begin
        if (!rose) begin
          rose = 1; len = 1; pmux = mux_refresh;
          check(mem_addr == a[11:0], {tag, " R1 address at rise"}, mem_addr, a[11:0]);
          check(mux_refresh == 1'b0, {tag, " R4 bus selector at rise"}, mux_refresh, 0);
        end else begin
          len++;
          if (flip < 0 && mux_refresh != pmux) flip = len - 1;
        end
        if (mem_we == oh) saw_we = 1;
      end else if (cen != 2'b00 && cen != 2'b11) saw_other = 1;
    end
    bus_req = 0;
    check(rose, {tag, " R1 strobe seen"}, rose, 1);
    check(!saw_other, {tag, " R2 only one bank"}, saw_other, 0);
    check(len == STROBE, {tag, " R5 strobe length"}, len, STROBE);
    check(flip == HOLD, {tag, " R5 selector flip"}, flip, HOLD);
    check(saw_we == exp_we, {tag, " R3 write gating"}, saw_we, exp_we);
    @(negedge clk);
    check(bus_ack == 1'b0, {tag, " R11 ack single"}, bus_ack, 0);
  endtask

  task automatic t_reset;
    check(cen == 0 && mem_we == 0, "R10 reset strobes", {cen, mem_we}, 0);
    check(bus_wait == 0 && bus_ack == 0, "R10 reset bus", {bus_wait, bus_ack}, 0);
    check(mux_refresh == 0, "R10 reset selector", mux_refresh, 0);
  endtask

  task automatic t_banks;
    protect_sel = 2'b00;
    run_access(16'h3ABC, 0, 0, 0, "rd b0");
    run_access(16'h9123, 1, 1, 1, "wr b1 pos0");
    protect_sel = 2'b01;
    run_access(16'h3FFF, 1, 0, 1, "wr b0 pos1");
  endtask

  task automatic t_protect;
    protect_sel = 2'b10;
    run_access(16'h9456, 1, 1, 0, "R3 wr protect10");
    protect_sel = 2'b11;
    run_access(16'h3001, 1, 0, 0, "R3 wr protect11");
    run_access(16'h9002, 0, 1, 0, "R3 rd protect");
    protect_sel = 2'b00;
  endtask

  task automatic t_overlap;
    base0 = 4'h5; base1 = 4'h5;
    run_access(16'h5777, 1, 0, 1, "R2 overlap");
    base0 = 4'h3; base1 = 4'h9;
  endtask

  task automatic t_miss;
    logic bad = 0;
    @(negedge clk);
    bus_addr = 16'h7123; bus_we = 1; bus_req = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if ((cen != 2'b00 && cen != 2'b11) || bus_wait || bus_ack) bad = 1;
    end
    bus_req = 0;
    check(!bad, "R9 miss quiet", bad, 0);
  endtask

  task automatic t_stall;
    int stall = 0;
    logic bad = 0;
    while (cen != 2'b11) @(negedge clk);
    bus_addr = 16'h3222; bus_we = 0; bus_req = 1;
    while (cen == 2'b11) begin
      #1 if (!bus_wait || bus_ack) bad = 1;
      stall++;
      @(negedge clk);
    end
    check(!bad, "R8 wait during refresh", bad, 0);
    check(stall > 0, "R8 stall observed", stall, 1);
    run_access(16'h3222, 0, 0, 0, "R8 after refresh");
  endtask

  task automatic t_wrap;
    int n = 0;
    while (ref_seen < 66 && n < 20000) begin @(negedge clk); n++; end
    check(ref_seen >= 66, "R7 row wrap reached", ref_seen, 66);
  endtask

  logic done = 0;
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    mon_on = 1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_protect();
    t_overlap();
    t_miss();
    t_stall();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule